// File: doc/BRIEF.md
# Selectable DMA Request Channel Router

This block steers one receive-side DMA request onto one of several request/acknowledge pin pairs that go to a host DMA controller. Software picks the pair by writing a small channel number into a select register. Only the chosen pair is driven. Every other pair has its output enable low, so the board sees those pins as floating. The acknowledge of the chosen pair is passed back to the frame-transfer logic as a single signal.

The request is raised when the receive side reports frames waiting for the host. How it is released depends on a burst control bit. With the bit clear, the request drops after the transfer-complete pulse of the current DMA operation. With the bit set, the request stays up until no frames remain pending, and transfer-complete pulses are ignored. A select value with no matching pair disconnects every pair.

Top module: `dmarq_router`

## Requirements
- R1: After reset the select register holds 0, so pair 0 is the only enabled pair, and every request line is low.
- R2: A select write of a value v below NUM_CH (0, 1 or 2 by default) makes `dreq_oe` one-hot with bit v set, starting the cycle after the write.
- R3: A select value of NUM_CH or above (3 by default) clears every bit of `dreq_oe` and forces `dack_sel` low.
- R4: A request line whose enable is low is driven 0.
- R5: While the request is low, a high `frames_pending` at a clock edge raises the request on that edge.
- R6: With `burst_mode` low, a high request falls on the edge where `xfer_done` is high. Without that pulse it stays high, even if `frames_pending` goes low.
- R7: With `burst_mode` high, `xfer_done` has no effect. A high request falls on the edge where `frames_pending` is low.
- R8: After the request falls it is low for at least one full cycle, even if frames are still pending.
- R9: `dack_sel` equals the acknowledge input of the selected pair. The acknowledge inputs of the other pairs have no effect on it.
- R10: The enabled request line carries the request state. When the select register changes, the request moves to the newly selected pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Write strobe for the channel select register |
| sel_wr_data | input | SEL_W | Channel number to store |
| frames_pending | input | 1 | Received frames are waiting for the host |
| xfer_done | input | 1 | The current DMA operation has completed |
| burst_mode | input | 1 | 1: hold the request until nothing is pending; 0: release it on completion |
| dack_in | input | NUM_CH | Acknowledge inputs, one per pair |
| dreq_out | output | NUM_CH | Request lines, one per pair |
| dreq_oe | output | NUM_CH | Output enables of the request lines (0 means high impedance) |
| dack_sel | output | 1 | Acknowledge of the selected pair |

## Verification
Directed sequences come first. They raise and release the request in each release mode, so a design that confuses `xfer_done` with `frames_pending` is caught in both directions. Each directed sequence also covers a pending flag that stays high across a release, which exposes a missing idle cycle. A select value of 3 combined with an active request and toggling acknowledges separates a true disconnect from a decode that wraps around to a real pair. The directed part also toggles only the unselected acknowledges. Long random runs then change the select register, burst bit and acknowledges while a request is live. These runs show whether the request follows the register to the new pair, and whether the acknowledge mux picks the right input for every channel number.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

   typedef enum logic [0:0] {
      REQ_IDLE   = 1'b0,
      REQ_ACTIVE = 1'b1
   } req_state_e;

   // Release condition for an active request
   function automatic logic req_release(input logic burst,
                                        input logic pending,
                                        input logic done);
      return burst ? !pending : done;
   endfunction

endpackage

// File: rtl/dmarq_sel_reg.sv
module dmarq_sel_reg #(
   parameter int NUM_CH = 3,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_data,
   output logic [SEL_W-1:0]  sel_q,
   output logic [NUM_CH-1:0] ch_en
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_en)
         sel_q <= wr_data;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      assign ch_en[i] = (sel_q == SEL_W'(i));
   end

endmodule

// File: rtl/dmarq_req_fsm.sv
module dmarq_req_fsm
   import dmarq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frames_pending,
   input  logic xfer_done,
   input  logic burst_mode,
   output logic req_active
);

   req_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         REQ_IDLE:   if (frames_pending) state_d = REQ_ACTIVE;
         REQ_ACTIVE: if (req_release(burst_mode, frames_pending, xfer_done))
                        state_d = REQ_IDLE;
         default:    state_d = REQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= REQ_IDLE;
      else        state_q <= state_d;
   end

   assign req_active = (state_q == REQ_ACTIVE);

endmodule

// File: rtl/dmarq_ack_mux.sv
module dmarq_ack_mux #(
   parameter int NUM_CH = 3
) (
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] dack_in,
   output logic              dack_sel
);

   logic [NUM_CH-1:0] term;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_term
      assign term[i] = ch_en[i] & dack_in[i];
   end

   assign dack_sel = |term;

endmodule

// File: rtl/dmarq_router.sv
module dmarq_router #(
   parameter int NUM_CH = 3,
   parameter int SEL_W  = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr_en,
   input  logic [SEL_W-1:0]  sel_wr_data,
   input  logic              frames_pending,
   input  logic              xfer_done,
   input  logic              burst_mode,
   input  logic [NUM_CH-1:0] dack_in,
   output logic [NUM_CH-1:0] dreq_out,
   output logic [NUM_CH-1:0] dreq_oe,
   output logic              dack_sel
);

   localparam int NUM_CODES = 1 << SEL_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dmarq_router: NUM_CH must be at least 1");
   end
   if (NUM_CODES <= NUM_CH) begin : g_bad_sel
      $error("dmarq_router: SEL_W must leave one code for no channel");
   end

   logic [SEL_W-1:0]  sel_q;
   logic [NUM_CH-1:0] ch_en;
   logic              req_active;

   dmarq_sel_reg #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel_wr_en),
      .wr_data (sel_wr_data),
      .sel_q   (sel_q),
      .ch_en   (ch_en)
   );

   dmarq_req_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .frames_pending (frames_pending),
      .xfer_done      (xfer_done),
      .burst_mode     (burst_mode),
      .req_active     (req_active)
   );

   dmarq_ack_mux #(.NUM_CH(NUM_CH)) u_ack (
      .ch_en    (ch_en),
      .dack_in  (dack_in),
      .dack_sel (dack_sel)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
      assign dreq_oe[i]  = ch_en[i];
      assign dreq_out[i] = ch_en[i] & req_active;
   end

endmodule

// File: rtl/dmarq_router_chk.sv
module dmarq_router_chk #(
   parameter int NUM_CH = 3,
   parameter int SEL_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_wr_en,
   input logic [SEL_W-1:0]  sel_wr_data,
   input logic              frames_pending,
   input logic              xfer_done,
   input logic              burst_mode,
   input logic [NUM_CH-1:0] dack_in,
   input logic [NUM_CH-1:0] dreq_out,
   input logic [NUM_CH-1:0] dreq_oe,
   input logic              dack_sel,
   input logic              req_active,
   input logic [SEL_W-1:0]  sel_q
);

   a_r2_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dreq_oe));

   a_r2_write_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr_en && sel_wr_data < SEL_W'(NUM_CH))
      |=> dreq_oe == (NUM_CH'(1) << $past(sel_wr_data)));

   a_r3_none: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q >= SEL_W'(NUM_CH)) |-> (dreq_oe == '0 && !dack_sel));

   a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_out & ~dreq_oe) == '0);

   a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_active && frames_pending) |=> req_active);

   a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && !burst_mode && xfer_done) |=> !req_active);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && !burst_mode && !xfer_done) |=> req_active);

   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && burst_mode && !frames_pending) |=> !req_active);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && burst_mode && frames_pending) |=> req_active);

   a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active && ((burst_mode && !frames_pending) || (!burst_mode && xfer_done)))
      |=> !req_active);

   a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_oe != '0) |-> ((|dreq_out) == req_active));

endmodule

bind dmarq_router dmarq_router_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sel_wr_en      (sel_wr_en),
   .sel_wr_data    (sel_wr_data),
   .frames_pending (frames_pending),
   .xfer_done      (xfer_done),
   .burst_mode     (burst_mode),
   .dack_in        (dack_in),
   .dreq_out       (dreq_out),
   .dreq_oe        (dreq_oe),
   .dack_sel       (dack_sel),
   .req_active     (req_active),
   .sel_q          (sel_q)
);

// File: tb/dmarq_router_test.sv
module dmarq_router_test;

   localparam int NCH = 3;
   localparam int SW  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sel_wr_en = 1'b0;
   logic [SW-1:0]  sel_wr_data = '0;
   logic           frames_pending = 1'b0;
   logic           xfer_done = 1'b0;
   logic           burst_mode = 1'b0;
   logic [NCH-1:0] dack_in = '0;
   logic [NCH-1:0] dreq_out, dreq_oe;
   logic           dack_sel;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // reference model state
   int m_sel = 0;
   bit m_req = 0;

   always #5 clk = ~clk;

   dmarq_router #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
      .frames_pending(frames_pending), .xfer_done(xfer_done), .burst_mode(burst_mode),
      .dack_in(dack_in), .dreq_out(dreq_out), .dreq_oe(dreq_oe), .dack_sel(dack_sel)
   );

   function automatic logic [NCH-1:0] exp_oe(int s);
      return (s < NCH) ? NCH'(1) << s : '0;
   endfunction

   function automatic logic exp_ack(int s, logic [NCH-1:0] a);
      return (s < NCH) ? a[s] : 1'b0;
   endfunction

   function automatic bit next_req(bit r, bit b, bit p, bit d);
      if (r) return b ? p : !d;
      return p;
   endfunction

   task automatic chk(string tag, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // Called at a negedge: drive inputs, check ack, clock once, check pins.
   task automatic step(string tag, bit wr, int wd, bit p, bit d, bit b, logic [NCH-1:0] a);
      sel_wr_en = wr; sel_wr_data = SW'(wd);
      frames_pending = p; xfer_done = d; burst_mode = b; dack_in = a;
      #1;
      chk(tag, "dack_sel", NCH'(dack_sel), NCH'(exp_ack(m_sel, a)));
      m_req = next_req(m_req, b, p, d);
      if (wr) m_sel = wd;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "dreq_oe", dreq_oe, exp_oe(m_sel));
      chk(tag, "dreq_out", dreq_out, m_req ? exp_oe(m_sel) : '0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "dreq_oe", dreq_oe, 3'b001);
      chk("R1", "dreq_out", dreq_out, 3'b000);
      rst_n = 1'b1;
      step("R1", 0, 0, 0, 0, 0, '0);

      // R2: select pair 1, R5: request rises
      step("R2", 1, 1, 0, 0, 0, '0);
      step("R5", 0, 0, 1, 0, 0, '0);
      // R6: pending drop does not release; done does
      step("R6", 0, 0, 0, 0, 0, '0);
      step("R6", 0, 0, 1, 1, 0, '0);
      // R8: still pending, low for one cycle then rises
      step("R8", 0, 0, 1, 0, 0, '0);
      // R7: burst ignores done, releases on empty
      step("R7", 0, 0, 1, 1, 1, '0);
      step("R7", 0, 0, 1, 1, 1, '0);
      step("R7", 0, 0, 0, 0, 1, '0);
      step("R8", 0, 0, 1, 0, 1, '0);
      // R10: request moves to pair 2
      step("R10", 1, 2, 1, 0, 1, '0);
      // R9: unselected acks ignored, selected passed
      step("R9", 0, 0, 1, 0, 1, 3'b011);
      step("R9", 0, 0, 1, 0, 1, 3'b100);
      // R3: no channel, R4: all off
      step("R3", 1, 3, 1, 0, 1, 3'b111);
      step("R3", 0, 0, 1, 0, 1, 3'b111);
      step("R4", 0, 0, 1, 1, 0, 3'b101);
      step("R2", 1, 0, 1, 0, 0, 3'b001);

      // R10: random mix
      for (int i = 0; i < 3000; i++) begin
         bit wr = ($urandom % 8) == 0;
         step("R10", wr, $urandom % 4, ($urandom % 4) != 0, ($urandom % 3) == 0,
              ($urandom % 16) < 7, NCH'($urandom));
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule